// File: doc/BRIEF.md
# Transmit Frame Check Sequence Inserter and Checker

This block sits in the transmit path of an Ethernet-style MAC and handles frames on a byte-wide valid/ready stream, one byte per cycle. It runs in one of two modes. In insert mode it computes a CRC-32 over the frame's bytes and appends the four check bytes after the last data byte. In pass-through mode the frame is expected to carry its own check sequence. The block forwards it untouched and verifies it on the way.

Every frame produces a one-cycle status pulse that marks the frame as good or bad and raises a separate bad-check flag. A software-visible ignore control decides whether a pass-through frame with a wrong check sequence still counts as good. When the control counts such a frame as good, the bad-check flag is still raised. The mode input is treated as static. It is taken only during reset and in idle cycles between frames.

Top module: `tx_fcs_unit`

## Requirements
- R1: With insert mode active, the output carries the frame's bytes and then four check bytes, least significant byte first. The check value is the CRC-32 with reflected polynomial 0xEDB88320 (0x04C11DB7 in normal form), seeded with 0xFFFFFFFF and inverted at the end. `out_last` is set only on the fourth check byte.
- R2: With insert mode off, the output bytes equal the input bytes exactly, nothing is appended, and `out_last` is set on the frame's own last byte.
- R3: A byte accepted (`in_valid` and `in_ready` high) at a clock edge appears on `out_data` with `out_valid` high in the cycle after that edge.
- R4: In insert mode `in_ready` goes low for exactly four cycles, starting the cycle after the last byte is accepted. Otherwise `in_ready` is high.
- R5: `stat_valid` is high for one cycle per frame, in exactly the cycle where `out_valid` and `out_last` are both high.
- R6: Frames sent in insert mode report `stat_good`=1 and `stat_bad_fcs`=0.
- R7: In pass-through mode the CRC register is run over the whole frame, including its last four bytes. `stat_bad_fcs` is 1 exactly when the result differs from the residue 0xC704DD7B, which is 0xDEBB20E3 in the reflected register form. A frame with a correct carried check sequence reports `stat_good`=1 and `stat_bad_fcs`=0.
- R8: For a pass-through frame with a wrong check sequence, `stat_good` equals the value of `ign_err` when that frame's last byte is accepted. `stat_bad_fcs` is 1 in both cases.
- R9: `ins_en` is sampled only during reset and in cycles with no open frame, no four-byte append running and `in_valid` low. A change of `ins_en` inside a frame does not affect that frame.
- R10: During and right after reset, `out_valid`=0, `stat_valid`=0 and `in_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ins_en | input | 1 | 1 = append check bytes, 0 = pass-through with checking (static) |
| ign_err | input | 1 | 1 = count a bad-check pass-through frame as good |
| in_data | input | 8 | Input byte |
| in_valid | input | 1 | Input byte present |
| in_last | input | 1 | Input byte is the frame's last |
| in_ready | output | 1 | Block can take a byte this cycle |
| out_data | output | 8 | Output byte |
| out_valid | output | 1 | Output byte present |
| out_last | output | 1 | Output byte ends the frame |
| stat_valid | output | 1 | Per-frame status pulse |
| stat_good | output | 1 | Frame counts as good |
| stat_bad_fcs | output | 1 | Carried check sequence was wrong |

## Verification
Two things can fall in the same clock cycle. The first is the close of one frame: the status pulse, `out_last`, and the reseeding of the CRC register. The second is the acceptance of the first byte of the next frame. The bench provokes this with pairs of frames driven with no gap, in both modes, and changes the ignore setting between the two frames. The pair passes when each frame gets its own status with its own ignore value and the second frame's check value is computed from a fresh seed. In insert mode, the second frame's first byte must wait out the four-cycle ready gap while it is held valid.

// File: rtl/tx_fcs_pkg.sv
package tx_fcs_pkg;
    typedef enum logic {
        S_DATA   = 1'b0,
        S_APPEND = 1'b1
    } fcs_state_e;
endpackage

// File: rtl/tx_fcs_crc_step.sv
// One byte of a reflected (LSB-first) CRC update, unrolled bit by bit.
module tx_fcs_crc_step #(
    parameter int                 CRC_W  = 32,
    parameter int                 BYTE_W = 8,
    parameter logic [CRC_W-1:0]   POLY   = 32'hEDB88320
) (
    input  logic [CRC_W-1:0]  crc_i,
    input  logic [BYTE_W-1:0] data_i,
    output logic [CRC_W-1:0]  crc_o
);
    logic [CRC_W-1:0] stage [0:BYTE_W];

    assign stage[0] = crc_i;

    for (genvar g = 0; g < BYTE_W; g++) begin : g_bit
        assign stage[g+1] = {1'b0, stage[g][CRC_W-1:1]}
                          ^ (POLY & {CRC_W{stage[g][0] ^ data_i[g]}});
    end

    assign crc_o = stage[BYTE_W];
endmodule

// File: rtl/tx_fcs_byte_pick.sv
// Selects one byte lane of a word; lane 0 is the least significant byte.
module tx_fcs_byte_pick #(
    parameter int BYTE_W = 8,
    parameter int LANES  = 4,
    parameter int SEL_W  = 2
) (
    input  logic [BYTE_W*LANES-1:0] word_i,
    input  logic [SEL_W-1:0]        sel_i,
    output logic [BYTE_W-1:0]       byte_o
);
    logic [BYTE_W-1:0] lane [0:LANES-1];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane[g] = word_i[g*BYTE_W +: BYTE_W];
    end

    assign byte_o = lane[sel_i];
endmodule

// File: rtl/tx_fcs_unit.sv
module tx_fcs_unit
    import tx_fcs_pkg::*;
#(
    parameter int               BYTE_W  = 8,
    parameter int               CRC_W   = 32,
    parameter logic [CRC_W-1:0] POLY    = 32'hEDB88320,
    parameter logic [CRC_W-1:0] SEED    = 32'hFFFFFFFF,
    parameter logic [CRC_W-1:0] RESIDUE = 32'hDEBB20E3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ins_en,
    input  logic              ign_err,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_valid,
    input  logic              in_last,
    output logic              in_ready,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_valid,
    output logic              out_last,
    output logic              stat_valid,
    output logic              stat_good,
    output logic              stat_bad_fcs
);
    localparam int FCS_BYTES = CRC_W / BYTE_W;
    localparam int CNT_W     = (FCS_BYTES > 1) ? $clog2(FCS_BYTES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FCS_BYTES - 1);

    typedef struct packed {
        fcs_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic [CRC_W-1:0]  crc;
        logic [CRC_W-1:0]  fcs;
        logic              ins_mode;
        logic              in_frame;
        logic [BYTE_W-1:0] odata;
        logic              ovalid;
        logic              olast;
        logic              svalid;
        logic              sgood;
        logic              sbad;
    } regs_t;

    regs_t r_d, r_q;

    logic [CRC_W-1:0]  crc_next;
    logic [BYTE_W-1:0] fcs_byte;
    logic              accept;

    tx_fcs_crc_step #(
        .CRC_W (CRC_W),
        .BYTE_W(BYTE_W),
        .POLY  (POLY)
    ) u_step (
        .crc_i (r_q.crc),
        .data_i(in_data),
        .crc_o (crc_next)
    );

    tx_fcs_byte_pick #(
        .BYTE_W(BYTE_W),
        .LANES (FCS_BYTES),
        .SEL_W (CNT_W)
    ) u_pick (
        .word_i(r_q.fcs),
        .sel_i (r_q.cnt),
        .byte_o(fcs_byte)
    );

    assign in_ready = (r_q.st == S_DATA);
    assign accept   = in_valid && in_ready;

    always_comb begin
        r_d        = r_q;
        r_d.ovalid = 1'b0;
        r_d.olast  = 1'b0;
        r_d.svalid = 1'b0;
        r_d.sgood  = 1'b0;
        r_d.sbad   = 1'b0;

        // Mode is taken only while nothing is in flight.
        if (r_q.st == S_DATA && !r_q.in_frame && !in_valid) begin
            r_d.ins_mode = ins_en;
        end

        unique case (r_q.st)
            S_DATA: begin
                if (accept) begin
                    r_d.odata    = in_data;
                    r_d.ovalid   = 1'b1;
                    r_d.crc      = crc_next;
                    r_d.in_frame = !in_last;
                    if (in_last) begin
                        r_d.crc = SEED;
                        if (r_q.ins_mode) begin
                            r_d.fcs = ~crc_next;
                            r_d.cnt = '0;
                            r_d.st  = S_APPEND;
                        end else begin
                            r_d.olast  = 1'b1;
                            r_d.svalid = 1'b1;
                            r_d.sbad   = (crc_next != RESIDUE);
                            r_d.sgood  = (crc_next == RESIDUE) || ign_err;
                        end
                    end
                end
            end
            S_APPEND: begin
                r_d.odata  = fcs_byte;
                r_d.ovalid = 1'b1;
                r_d.cnt    = r_q.cnt + CNT_W'(1);
                if (r_q.cnt == CNT_LAST) begin
                    r_d.olast  = 1'b1;
                    r_d.svalid = 1'b1;
                    r_d.sgood  = 1'b1;
                    r_d.st     = S_DATA;
                end
            end
            default: r_d.st = S_DATA;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q          <= '0;
            r_q.st       <= S_DATA;
            r_q.crc      <= SEED;
            r_q.ins_mode <= ins_en;
        end else begin
            r_q <= r_d;
        end
    end

    assign out_data     = r_q.odata;
    assign out_valid    = r_q.ovalid;
    assign out_last     = r_q.olast;
    assign stat_valid   = r_q.svalid;
    assign stat_good    = r_q.sgood;
    assign stat_bad_fcs = r_q.sbad;
endmodule

// File: rtl/tx_fcs_unit_chk.sv
module tx_fcs_unit_chk #(
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ign_err,
    input logic [BYTE_W-1:0] in_data,
    input logic              in_valid,
    input logic              in_ready,
    input logic [BYTE_W-1:0] out_data,
    input logic              out_valid,
    input logic              out_last,
    input logic              stat_valid,
    input logic              stat_good,
    input logic              stat_bad_fcs
);
    // R3: accepted byte shows up one cycle later
    a_r3_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (out_valid && out_data == $past(in_data)));

    // R4: ready gap lasts exactly four cycles
    a_r4_ready_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_ready) |-> ##1 !in_ready ##1 !in_ready ##1 !in_ready ##1 in_ready);

    // R4: while ready is low the appended bytes stream out
    a_r4_append_streams: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |=> out_valid);

    // R5: status pulse lines up with the frame's final output byte
    a_r5_stat_on_last: assert property (@(posedge clk) disable iff (!rst_n)
        stat_valid == (out_valid && out_last));

    // R6, R7: no bad flag means a good frame
    a_r7_clean_is_good: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_valid && !stat_bad_fcs) |-> stat_good);

    // R8: bad frame counts as good only under the ignore control
    a_r8_ignore_decides: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_valid && stat_bad_fcs) |-> (stat_good == $past(ign_err)));
endmodule

bind tx_fcs_unit tx_fcs_unit_chk #(.BYTE_W(BYTE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ign_err     (ign_err),
    .in_data     (in_data),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .out_data    (out_data),
    .out_valid   (out_valid),
    .out_last    (out_last),
    .stat_valid  (stat_valid),
    .stat_good   (stat_good),
    .stat_bad_fcs(stat_bad_fcs)
);

// File: tb/tx_fcs_unit_test.sv
`timescale 1ns/1ps
module tx_fcs_unit_test;
    typedef logic [7:0] bq_t[$];

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ins_en = 1'b0;
    logic       ign_err = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_valid = 1'b0;
    logic       in_last = 1'b0;
    logic       in_ready;
    logic [7:0] out_data;
    logic       out_valid, out_last, stat_valid, stat_good, stat_bad_fcs;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    bq_t cap_d, cap_l, cap_s;
    int  low_cnt = 0;
    int  last_run = 0;

    always #2.5 clk = ~clk;

    tx_fcs_unit uut (
        .clk(clk), .rst_n(rst_n), .ins_en(ins_en), .ign_err(ign_err),
        .in_data(in_data), .in_valid(in_valid), .in_last(in_last),
        .in_ready(in_ready), .out_data(out_data), .out_valid(out_valid),
        .out_last(out_last), .stat_valid(stat_valid), .stat_good(stat_good),
        .stat_bad_fcs(stat_bad_fcs)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid) begin
                cap_d.push_back(out_data);
                cap_l.push_back({7'b0, out_last});
            end
            if (stat_valid) cap_s.push_back({6'b0, stat_good, stat_bad_fcs});
            if (!in_ready) low_cnt++;
            else if (low_cnt != 0) begin
                last_run = low_cnt;
                low_cnt  = 0;
            end
        end
    end

    function automatic logic [31:0] fcs_of(bq_t b);
        logic [31:0] c = 32'hFFFFFFFF;
        foreach (b[i]) begin
            for (int k = 0; k < 8; k++) begin
                if (c[0] ^ b[i][k]) c = (c >> 1) ^ 32'hEDB88320;
                else                c = c >> 1;
            end
        end
        return ~c;
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic clear_caps();
        cap_d.delete();
        cap_l.delete();
        cap_s.delete();
        last_run = 0;
    endtask

    // f[i] bit0 = last, bit1 = ignore value presented with byte i
    task automatic drive(bq_t b, bq_t f, bit gaps, bit flip);
        int  i = 0;
        bit  flipped = 1'b0;
        while (i < b.size()) begin
            @(negedge clk);
            if (flip && !flipped && i >= 1) begin
                ins_en  = ~ins_en;
                flipped = 1'b1;
            end
            if (gaps && $urandom_range(3) == 0) begin
                in_valid = 1'b0;
            end else begin
                in_valid = 1'b1;
                in_data  = b[i];
                in_last  = f[i][0];
                ign_err  = f[i][1];
                if (in_ready) i++;
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
        if (flipped) ins_en = ~ins_en;
    endtask

    task automatic compare(bq_t ed, bq_t el, bq_t es, int exp_run,
                           string rd, string rs);
        int n;
        repeat (8) @(negedge clk);
        chk(rd, "byte count", cap_d.size(), ed.size());
        n = (cap_d.size() < ed.size()) ? cap_d.size() : ed.size();
        for (int i = 0; i < n; i++) begin
            chk(rd, $sformatf("byte %0d", i), cap_d[i], ed[i]);
            chk("R5", $sformatf("last flag %0d", i), cap_l[i], el[i]);
        end
        chk("R5", "status count", cap_s.size(), es.size());
        n = (cap_s.size() < es.size()) ? cap_s.size() : es.size();
        for (int i = 0; i < n; i++)
            chk(rs, $sformatf("status {good,bad} %0d", i), cap_s[i], es[i]);
        chk("R4", "ready low run", last_run, exp_run);
        clear_caps();
    endtask

    task automatic set_mode(bit m);
        @(negedge clk);
        in_valid = 1'b0;
        ins_en   = m;
        repeat (3) @(negedge clk);
    endtask

    // Builds one frame and the output expected from it.
    task automatic build(bit ins, bit ign, bit bad, bq_t d,
                         output bq_t st, output bq_t f, output bq_t ed,
                         output bq_t el, output bq_t es);
        logic [31:0] c = fcs_of(d);
        bq_t tail = '{c[7:0], c[15:8], c[23:16], c[31:24]};
        st = d;
        if (!ins) begin
            st = {d, tail};
            if (bad) st[st.size()-1] = st[st.size()-1] ^ 8'h10;
        end
        ed = ins ? {d, tail} : st;
        el = {};
        foreach (ed[i]) el.push_back({7'b0, i == ed.size() - 1});
        f = {};
        foreach (st[i]) f.push_back({6'b0, ign, i == st.size() - 1});
        if (ins) es = '{8'b10};
        else     es = '{{6'b0, (!bad || ign), bad}};
    endtask

    task automatic one_frame(bit ins, bit ign, bit bad, int len, bit gaps, bit flip);
        bq_t d, st, f, ed, el, es;
        string rs;
        for (int i = 0; i < len; i++) d.push_back(8'($urandom));
        build(ins, ign, bad, d, st, f, ed, el, es);
        clear_caps();
        drive(st, f, gaps, flip);
        rs = ins ? "R6" : (bad ? "R8" : "R7");
        compare(ed, el, es, ins ? 4 : 0,
                flip ? "R9" : (ins ? "R1" : "R2"), flip ? "R9" : rs);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        bq_t d, st, f, ed, el, es, st2, f2, ed2, el2, es2;
        void'($urandom(32'd8117));

        // R10: reset state
        ins_en = 1'b1;
        repeat (4) @(negedge clk);
        chk("R10", "out_valid in reset", out_valid, 1'b0);
        chk("R10", "stat_valid in reset", stat_valid, 1'b0);
        chk("R10", "in_ready in reset", in_ready, 1'b1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10", "out_valid after reset", out_valid, 1'b0);
        chk("R10", "in_ready after reset", in_ready, 1'b1);

        // R1: known vector "123456789" -> CBF43926, sent LSB first
        clear_caps();
        d = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
        build(1'b1, 1'b0, 1'b0, d, st, f, ed, el, es);
        ed = {d, 8'h26, 8'h39, 8'hF4, 8'hCB};
        drive(st, f, 1'b0, 1'b0);
        compare(ed, el, es, 4, "R1", "R6");

        // R3, R5, R8: one-byte pass-through frame, latency and status timing
        set_mode(1'b0);
        clear_caps();
        @(negedge clk);
        in_valid = 1'b1; in_data = 8'hA5; in_last = 1'b1; ign_err = 1'b0;
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
        chk("R3", "out_valid one cycle later", out_valid, 1'b1);
        chk("R3", "out_data one cycle later", out_data, 8'hA5);
        chk("R5", "stat_valid with last", stat_valid, 1'b1);
        chk("R8", "short frame bad flag", stat_bad_fcs, 1'b1);
        chk("R8", "short frame good with ignore off", stat_good, 1'b0);
        @(negedge clk);
        chk("R5", "status is one cycle", stat_valid, 1'b0);
        repeat (4) @(negedge clk);
        clear_caps();

        // R7, R8: directed pass-through cases
        one_frame(1'b0, 1'b0, 1'b0, 10, 1'b0, 1'b0);
        one_frame(1'b0, 1'b0, 1'b1, 10, 1'b0, 1'b0);
        one_frame(1'b0, 1'b1, 1'b1, 10, 1'b1, 1'b0);
        one_frame(1'b0, 1'b1, 1'b0, 1, 1'b0, 1'b0);

        // R9: mode flipped inside a frame has no effect
        one_frame(1'b0, 1'b0, 1'b0, 12, 1'b1, 1'b1);
        set_mode(1'b1);
        one_frame(1'b1, 1'b0, 1'b0, 12, 1'b1, 1'b1);

        // Back-to-back pairs: frame close meets next frame's first byte
        for (int m = 0; m < 2; m++) begin
            set_mode(m[0]);
            d = {};
            for (int i = 0; i < 6; i++) d.push_back(8'($urandom));
            build(m[0], 1'b0, 1'b1, d, st, f, ed, el, es);
            d = {};
            for (int i = 0; i < 5; i++) d.push_back(8'($urandom));
            build(m[0], 1'b1, 1'b1, d, st2, f2, ed2, el2, es2);
            clear_caps();
            drive({st, st2}, {f, f2}, 1'b0, 1'b0);
            compare({ed, ed2}, {el, el2}, {es, es2}, m[0] ? 4 : 0,
                    m[0] ? "R1" : "R2", m[0] ? "R6" : "R8");
        end

        // Random frames across both modes
        for (int n = 0; n < 60; n++) begin
            bit ins = 1'($urandom);
            set_mode(ins);
            one_frame(ins, 1'($urandom), ($urandom_range(2) == 0),
                      1 + $urandom_range(15), 1'b1, 1'b0);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule